// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in an Ethernet receive path and decides, from the 48-bit destination address alone, whether an incoming frame is kept. Address bytes arrive one at a time behind a frame-start strobe. The block compares them against a programmed station address and, at the same time, runs a CRC-32 over them. Once the sixth byte has been taken it issues one accept or reject verdict with a one-cycle valid strobe.

Individual (unicast) addresses need an exact match to the station address. A global unicast-reject bit overrides that match. Group (multicast) addresses are hashed: six bits of the address-only CRC select one bit of a 64-bit table, and that bit decides the frame. The all-ones broadcast address goes through the hash unless an accept-broadcast bit is set. Frames that the receive MAC flags as control frames do not get an address verdict. They get a bypass indication instead.

Configuration lives in eight 16-bit registers that are written through a simple index/data port. Each frame uses a private copy of the configuration, taken at its frame start.

Top module: `rx_da_filter`

## Requirements
- R1: A unicast frame is accepted only when all six received address bytes equal the station address. Register 0 holds bytes 1 (bits 7:0) and 2 (bits 15:8), register 1 holds bytes 3 and 4, and register 2 holds bytes 5 and 6. Byte 1 is the first byte received.
- R2: When bit 0 of register 7 (reject-unicast) is 1, every unicast frame is rejected, including one whose address matches.
- R3: A frame is multicast when bit 0 of its first address byte is 1, and unicast when that bit is 0.
- R4: The multicast CRC is preset to all ones before the first address byte. It shifts in each of the six bytes least significant bit first, using the reflected polynomial 0xEDB88320. No final inversion is applied.
- R5: The 64-bit hash table is held as bits 15:0 in register 3, bits 31:16 in register 4, bits 47:32 in register 5 and bits 63:48 in register 6. CRC bits 2:0 give a byte number B and CRC bits 5:3 give a bit number b. The frame is accepted when table bit 8*B+b is 1.
- R6: The all-ones address is hashed like any other multicast address. When bit 1 of register 7 (accept-broadcast) is 1, the all-ones address is always accepted.
- R7: A frame whose ctl_frame_i was high in its frame-start cycle reports bypass_o=1 and accept_o=0 with its verdict, whatever its address and settings. Other frames report bypass_o=0.
- R8: dec_vld_o is high for exactly one cycle per frame. That cycle directly follows the clock edge that takes the sixth address byte. Bytes after the sixth do not produce another verdict.
- R9: A register write takes effect at the next frame start. A write made in the frame-start cycle itself, or in the middle of a frame, does not affect the current frame's verdict.
- R10: After reset all outputs are 0. Bytes presented before the first frame start, or in a frame-start cycle, are not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_idx_i | input | 3 | Register index, 0 to 7 |
| cfg_wdata_i | input | 16 | Register write data |
| sof_i | input | 1 | Frame start strobe |
| ctl_frame_i | input | 1 | Frame is a MAC control frame; sampled with sof_i |
| byte_vld_i | input | 1 | Address byte valid |
| byte_i | input | 8 | Address byte, first received byte first |
| dec_vld_o | output | 1 | Verdict valid, one-cycle pulse |
| accept_o | output | 1 | Frame accepted, valid with dec_vld_o |
| bypass_o | output | 1 | Control frame bypass, valid with dec_vld_o |

## Verification
A configuration write and a frame start can land in the same cycle, and so can a write and the address bytes of a frame in flight. The bench drives a station-address write in the exact cycle that sof_i is high. It then requires the old address to be accepted in that frame, and only the new address to be accepted in the frame after. A second case rewrites a station register while the third byte is on the bus and again expects the verdict to use the settings in force at frame start.

// File: rtl/rx_daf_pkg.sv
package rx_daf_pkg;
  localparam int DA_BYTES = 6;
  localparam int DA_W     = 8 * DA_BYTES;
  localparam int HASH_W   = 64;
  localparam int REG_W    = 16;
  localparam int STA_REGS = DA_W / REG_W;
  localparam int TBL_REGS = HASH_W / REG_W;
  localparam int NREG     = STA_REGS + TBL_REGS + 1;
  localparam int IDX_W    = $clog2(NREG);
  localparam int HIDX_W   = $clog2(HASH_W);
  localparam int SEL_W    = HIDX_W / 2;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic [DA_W-1:0]   sta;
    logic [HASH_W-1:0] tbl;
    logic              rej_uc;
    logic              acc_bc;
  } daf_cfg_t;

  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) r = (r >> 1) ^ ((r[0] ^ b[k]) ? CRC_POLY : 32'h0);
    return r;
  endfunction
endpackage

// File: rtl/rx_daf_cfg.sv
module rx_daf_cfg
  import rx_daf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             sof_i,
  output daf_cfg_t         cfg_o
);
  logic [NREG-1:0][REG_W-1:0] regs_q;
  daf_cfg_t live, shd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    regs_q <= '0;
    else if (we_i)  regs_q[idx_i] <= wdata_i;
  end

  always_comb begin
    live.sta    = regs_q[STA_REGS-1:0];
    live.tbl    = regs_q[STA_REGS+TBL_REGS-1:STA_REGS];
    live.rej_uc = regs_q[NREG-1][0];
    live.acc_bc = regs_q[NREG-1][1];
  end

  // per-frame copy: settings frozen at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shd_q <= '0;
    else if (sof_i)  shd_q <= live;
  end

  assign cfg_o = shd_q;

  a_r9_frame_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(cfg_o));
endmodule

// File: rtl/rx_daf_crc.sv
module rx_daf_crc
  import rx_daf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o,
  output logic [31:0] crc_nxt_o
);
  logic [31:0] crc_q;

  assign crc_nxt_o = crc32_byte(crc_q, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (clr_i)  crc_q <= '1;
    else if (en_i)   crc_q <= crc_nxt_o;
  end

  assign crc_o = crc_q;

  a_r4_crc_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(crc_o));
endmodule

// File: rtl/rx_daf_match.sv
module rx_daf_match
  import rx_daf_pkg::*;
#(
  parameter int NBYTES = DA_BYTES,
  localparam int AW    = 8 * NBYTES,
  localparam int CNT_W = $clog2(NBYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sof_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic [AW-1:0] sta_i,
  output logic          take_o,
  output logic          last_o,
  output logic          grp_o,
  output logic          uc_hit_o,
  output logic          bc_hit_o
);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(NBYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NBYTES - 1);

  logic             active_q, uc_q, bc_q, grp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sta_byte;

  assign sta_byte = sta_i[8*cnt_q +: 8];
  assign take_o   = active_q && byte_vld_i && !sof_i && (cnt_q != CNT_END);
  assign last_o   = take_o && (cnt_q == CNT_LAST);
  assign uc_hit_o = uc_q && (byte_i == sta_byte);
  assign bc_hit_o = bc_q && (&byte_i);
  assign grp_o    = grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      uc_q     <= 1'b0;
      bc_q     <= 1'b0;
      grp_q    <= 1'b0;
    end else if (sof_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      uc_q     <= 1'b1;
      bc_q     <= 1'b1;
      grp_q    <= 1'b0;
    end else if (take_o) begin
      cnt_q <= cnt_q + 1'b1;
      uc_q  <= uc_hit_o;
      bc_q  <= bc_hit_o;
      if (cnt_q == '0) grp_q <= byte_i[0];
    end
  end

  a_r8_cnt_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_END && !sof_i) |=> (cnt_q == CNT_END));
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_daf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  input  logic             sof_i,
  input  logic             ctl_frame_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  output logic             dec_vld_o,
  output logic             accept_o,
  output logic             bypass_o
);
  daf_cfg_t          cfg;
  logic [31:0]       crc_q, crc_nxt;
  logic              take, last, grp, uc_hit, bc_hit;
  logic              ctl_q, hash_hit, acc_d;
  logic [HIDX_W-1:0] hidx;
  logic              dec_q, acc_q, byp_q;

  rx_daf_cfg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .idx_i(cfg_idx_i), .wdata_i(cfg_wdata_i),
    .sof_i, .cfg_o(cfg)
  );

  rx_daf_crc u_crc (
    .clk_i, .rst_ni, .clr_i(sof_i), .en_i(take), .byte_i,
    .crc_o(crc_q), .crc_nxt_o(crc_nxt)
  );

  rx_daf_match #(.NBYTES(DA_BYTES)) u_match (
    .clk_i, .rst_ni, .sof_i, .byte_vld_i, .byte_i, .sta_i(cfg.sta),
    .take_o(take), .last_o(last), .grp_o(grp), .uc_hit_o(uc_hit), .bc_hit_o(bc_hit)
  );

  // low CRC bits pick the byte, next bits pick the bit in it
  assign hidx     = {crc_nxt[SEL_W-1:0], crc_nxt[2*SEL_W-1:SEL_W]};
  assign hash_hit = cfg.tbl[hidx];

  always_comb begin
    if (ctl_q)    acc_d = 1'b0;
    else if (grp) acc_d = (bc_hit && cfg.acc_bc) || hash_hit;
    else          acc_d = !cfg.rej_uc && uc_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= 1'b0;
    else if (sof_i)  ctl_q <= ctl_frame_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= 1'b0;
      acc_q <= 1'b0;
      byp_q <= 1'b0;
    end else begin
      dec_q <= last;
      acc_q <= last && acc_d;
      byp_q <= last && ctl_q;
    end
  end

  assign dec_vld_o = dec_q;
  assign accept_o  = acc_q;
  assign bypass_o  = byp_q;

  a_r8_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o |=> !dec_vld_o);
  a_r8_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o |-> $past(byte_vld_i));
  a_r7_bypass_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_vld_o && bypass_o) |-> !accept_o);
  a_r2_reject_unicast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_vld_o && !bypass_o && cfg.rej_uc && !grp) |-> !accept_o);
  a_r10_quiet_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_vld_o |-> (!accept_o && !bypass_o));
  a_r4_crc_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (crc_q == 32'hFFFF_FFFF));
endmodule

// File: tb/rx_da_filter_test.sv
module rx_da_filter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        sof_i = 1'b0;
  logic        ctl_frame_i = 1'b0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        dec_vld_o, accept_o, bypass_o;

  int checks = 0;
  int errors = 0;

  logic [47:0] m_sta = '0;
  logic [63:0] m_tbl = '0;
  logic        m_rej = 1'b0;
  logic        m_abc = 1'b0;

  rx_da_filter uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] da);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 8; j++) begin
        fb = c[0] ^ da[8*i+j];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return {c[2:0], c[5:3]};
  endfunction

  function automatic logic ref_acc(input logic [47:0] da, input logic ctl);
    if (ctl) return 1'b0;
    if (da[0]) return ((da == '1) && m_abc) || m_tbl[ref_idx(da)];
    return !m_rej && (da == m_sta);
  endfunction

  task automatic wr(input int idx, input logic [15:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 3'(idx); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_sta(input logic [47:0] s);
    for (int k = 0; k < 3; k++) wr(k, s[16*k +: 16]);
    m_sta = s;
  endtask

  task automatic set_tbl(input logic [63:0] t);
    for (int k = 0; k < 4; k++) wr(3 + k, t[16*k +: 16]);
    m_tbl = t;
  endtask

  task automatic set_ctl(input logic rej, input logic abc);
    wr(7, {14'd0, abc, rej});
    m_rej = rej; m_abc = abc;
  endtask

  // frame with optional writes in the sof cycle and at the third byte
  task automatic run_frame(input logic [47:0] da, input logic ctl, input int nbytes,
                           input logic wsof, input logic wmid, input int widx,
                           input logic [15:0] wdat,
                           output int npulse, output int pos, output logic a, output logic b);
    npulse = 0; pos = -1; a = 1'b0; b = 1'b0;
    @(negedge clk_i);
    sof_i = 1'b1; ctl_frame_i = ctl;
    if (wsof) begin cfg_we_i = 1'b1; cfg_idx_i = 3'(widx); cfg_wdata_i = wdat; end
    @(negedge clk_i);
    sof_i = 1'b0; ctl_frame_i = 1'b0; cfg_we_i = 1'b0;
    for (int i = 0; i < nbytes; i++) begin
      byte_vld_i = 1'b1;
      byte_i = (i < 6) ? da[8*i +: 8] : 8'hA5;
      if (wmid && i == 2) begin cfg_we_i = 1'b1; cfg_idx_i = 3'(widx); cfg_wdata_i = wdat; end
      @(negedge clk_i);
      cfg_we_i = 1'b0;
      if (dec_vld_o) begin
        npulse++;
        if (pos < 0) begin pos = i; a = accept_o; b = bypass_o; end
      end
    end
    byte_vld_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      if (dec_vld_o) npulse++;
    end
  endtask

  task automatic frame_check(input logic [47:0] da, input logic ctl, input string tag);
    int np, ps; logic a, b, ea;
    ea = ref_acc(da, ctl);
    run_frame(da, ctl, 6, 1'b0, 1'b0, 0, 16'h0, np, ps, a, b);
    check(np == 1 && ps == 5, {tag, " R8 strobe"}, np * 10 + ps, 15);
    check(a == ea, {tag, " accept"}, int'(a), int'(ea));
    check(b == ctl, {tag, " R7 bypass"}, int'(b), int'(ctl));
  endtask

  task automatic t_reset;
    check(!dec_vld_o && !accept_o && !bypass_o, "R10 reset outputs",
          int'({dec_vld_o, accept_o, bypass_o}), 0);
  endtask

  task automatic t_no_sof;
    int np = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i); byte_vld_i = 1'b1; byte_i = 8'(i);
    end
    @(negedge clk_i); byte_vld_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); if (dec_vld_o) np++;
    end
    check(np == 0, "R10 bytes before sof", np, 0);
  endtask

  task automatic t_unicast;
    set_ctl(1'b0, 1'b0);
    set_sta(48'h5544_3322_1100);
    frame_check(48'h5544_3322_1100, 1'b0, "R1 exact match");
    frame_check(48'h5544_3322_1102, 1'b0, "R1 R3 first byte differs");
    frame_check(48'h5444_3322_1100, 1'b0, "R1 last byte differs");
    set_sta(48'hFEDC_BA98_7654);
    frame_check(48'hFEDC_BA98_7654, 1'b0, "R1 second station");
  endtask

  task automatic t_reject_uc;
    set_ctl(1'b1, 1'b0);
    frame_check(m_sta, 1'b0, "R2 reject matching unicast");
    set_ctl(1'b0, 1'b0);
    frame_check(m_sta, 1'b0, "R2 reject cleared");
  endtask

  task automatic t_multicast;
    logic [47:0] das [3];
    das[0] = 48'h0100_005E_0001;
    das[1] = 48'h0000_0000_0033;
    das[2] = 48'hC200_0000_8001;
    for (int k = 0; k < 3; k++) begin
      set_tbl(64'h0);
      frame_check(das[k], 1'b0, "R3 R5 empty table");
      set_tbl(64'h1 << ref_idx(das[k]));
      frame_check(das[k], 1'b0, "R4 R5 single bit hit");
      set_tbl(~(64'h1 << ref_idx(das[k])));
      frame_check(das[k], 1'b0, "R4 R5 single bit miss");
    end
    set_tbl(64'h0);
    set_ctl(1'b1, 1'b0);
    set_tbl(64'h1 << ref_idx(das[0]));
    frame_check(das[0], 1'b0, "R2 R3 reject-unicast spares multicast");
    set_ctl(1'b0, 1'b0);
  endtask

  task automatic t_bcast;
    set_tbl(64'h0);
    set_ctl(1'b0, 1'b0);
    frame_check('1, 1'b0, "R6 broadcast hashed miss");
    set_ctl(1'b0, 1'b1);
    frame_check('1, 1'b0, "R6 broadcast forced accept");
    set_ctl(1'b0, 1'b0);
    set_tbl(64'h1 << ref_idx('1));
    frame_check('1, 1'b0, "R6 broadcast hashed hit");
    set_tbl(64'h0);
  endtask

  task automatic t_ctl;
    set_sta(48'h0A0B_0C0D_0E10);
    frame_check(48'h0A0B_0C0D_0E10, 1'b1, "R7 control unicast");
    set_tbl('1);
    frame_check(48'h0100_00C2_8001, 1'b1, "R7 control multicast");
    frame_check(48'h0A0B_0C0D_0E10, 1'b0, "R7 normal after control");
    set_tbl(64'h0);
  endtask

  task automatic t_long;
    int np, ps; logic a, b;
    run_frame(m_sta, 1'b0, 9, 1'b0, 1'b0, 0, 16'h0, np, ps, a, b);
    check(np == 1, "R8 extra bytes single verdict", np, 1);
    check(ps == 5, "R8 verdict after sixth byte", ps, 5);
    check(a == 1'b1, "R8 long frame accept", int'(a), 1);
  endtask

  task automatic t_cfg_timing;
    int np, ps; logic a, b;
    logic [47:0] old_s;
    old_s = m_sta;
    set_ctl(1'b0, 1'b0);
    // write station low word in the sof cycle
    run_frame(old_s, 1'b0, 6, 1'b1, 1'b0, 0, 16'h7788, np, ps, a, b);
    check(np == 1 && a == 1'b1, "R9 sof-cycle write not used", int'(a), 1);
    m_sta[15:0] = 16'h7788;
    frame_check(old_s, 1'b0, "R9 old address after write");
    frame_check(m_sta, 1'b0, "R9 new address after write");
    // mid-frame write of station middle word
    run_frame(m_sta, 1'b0, 6, 1'b0, 1'b1, 1, 16'h1234, np, ps, a, b);
    check(np == 1 && a == 1'b1, "R9 mid-frame write not used", int'(a), 1);
    m_sta[31:16] = 16'h1234;
    frame_check(m_sta, 1'b0, "R9 mid-frame write applied next");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_no_sof();
    t_unicast();
    t_reject_uc();
    t_multicast();
    t_bcast();
    t_ctl();
    t_long();
    t_cfg_timing();
    repeat (2) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule